// File: doc/BRIEF.md
# Receive Sampling Tap Sweep Engine

This engine searches for the receive sampling delay tap that sits most safely inside the window of working taps on a high speed card link. After a start pulse it steps a 6-bit tap value upward from tap 0. Each tap is loaded into the receive delay line through an update handshake. An external checker then reports whether a tuning block was received correctly at that tap.

The engine records the longest run of adjacent passing taps and the tap that ends it. When the sweep is over, it loads the tap at the centre of that run through the same handshake and raises a done pulse. If no tap passed, or if the centre tap could not be loaded, it flags an error.

A tap value is always loaded twice in a row, because the receive path may not settle on the first load. The sweep stops at tap 39. The field is wider than that, but its upper codes either wrap around or are unsafe to use.

Top module: `rx_tap_sweep`

## Requirements
- R1: After reset, busy, done, err, upd_req and test_req are 0 and tap_value is 0.
- R2: A start pulse begins a sweep only when timing_mode equals the HS200 code 3'b100. With any other code the start is ignored: busy stays 0 and no update request appears.
- R3: The sweep visits taps 0 to 39 in ascending order and never presents a tap above 39. It raises test_req exactly once for every tap that loaded successfully. tap_value is held stable while upd_req or test_req is high.
- R4: Loading a tap takes two update requests in sequence. Each request holds upd_req high until upd_ack is seen, and upd_req drops in the cycle after the ack. The second request starts only after the first has been acknowledged.
- R5: If upd_ack does not arrive within TO_CYC cycles of upd_req rising, upd_req is withdrawn and the tap counts as failed. No test request is made for that tap, and no second update request follows a timed-out first one.
- R6: A pass extends the current run of passing taps, and a fail resets it to zero. The best run is replaced only by a strictly longer run, so when two runs have equal length the earlier one is kept.
- R7: If any tap passed, the final tap is the best run's end tap minus half the run length, rounded down. It is loaded with two update requests. The engine then pulses done with err at 0, and final_tap carries that value.
- R8: If no tap passed, done pulses with err at 1 and no update request is made after the sweep.
- R9: If the final tap load times out, done pulses with err at 1.
- R10: done is high for exactly one cycle, and busy is 0 from that cycle onward until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start a sweep (pulse) |
| timing_mode | input | 3 | Current bus timing code; only 3'b100 is accepted |
| busy | output | 1 | A sweep or final load is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Error flag, valid with done, held until next start |
| final_tap | output | 6 | Tap loaded at the end of a successful sweep |
| tap_value | output | 6 | Tap presented to the delay line |
| upd_req | output | 1 | Update request for tap_value |
| upd_ack | input | 1 | Delay line has taken the value (one-cycle pulse) |
| test_req | output | 1 | Ask the checker to test the current tap |
| test_rsp_valid | input | 1 | Checker result strobe |
| test_pass | input | 1 | Checker result, valid with test_rsp_valid |

## Verification
A corrupted run counter or best-run register does not show up during the sweep. It appears only at the done pulse, as a wrong final_tap or a wrong err. For that reason every scenario compares final_tap against an arithmetic model over the full 40-tap pass pattern, including equal-length runs, runs at both ends, and patterns where every tap passes or none does. Faults in the load handshake show up sooner, in the number of update request edges counted per run and in the set of taps that were tested. A fault in the timeout counter shows up when a deliberately stalled tap is tested anyway, or when the run never finishes.

// File: rtl/rx_tune_pkg.sv
package rx_tune_pkg;

    typedef enum logic [2:0] {
        SW_IDLE,
        SW_APPLY,
        SW_TEST,
        SW_EVAL,
        SW_FINAL
    } sweep_st_e;

    typedef enum logic [1:0] {
        AP_IDLE,
        AP_REQ,
        AP_GAP
    } apply_st_e;

    localparam int unsigned LOADS_PER_TAP = 2;

endpackage

// File: rtl/rx_tap_apply.sv
module rx_tap_apply
    import rx_tune_pkg::*;
#(
    parameter int unsigned TO_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic upd_ack,
    output logic upd_req,
    output logic done,
    output logic ok
);
    localparam int unsigned CNT_W = $clog2(TO_CYC + 1);
    localparam int unsigned RND_W = $clog2(LOADS_PER_TAP + 1);

    typedef struct packed {
        apply_st_e        st;
        logic [RND_W-1:0] rnd;
        logic [CNT_W-1:0] cnt;
        logic             done;
        logic             ok;
    } ap_t;

    ap_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            AP_IDLE: begin
                if (go) begin
                    r_d.st  = AP_REQ;
                    r_d.rnd = '0;
                    r_d.cnt = '0;
                end
            end
            AP_REQ: begin
                if (upd_ack) begin
                    r_d.cnt = '0;
                    if (r_q.rnd == RND_W'(LOADS_PER_TAP - 1)) begin
                        r_d.st   = AP_IDLE;
                        r_d.done = 1'b1;
                        r_d.ok   = 1'b1;
                    end else begin
                        r_d.rnd = r_q.rnd + 1'b1;
                        r_d.st  = AP_GAP;
                    end
                end else if (r_q.cnt == CNT_W'(TO_CYC - 1)) begin
                    r_d.st   = AP_IDLE;
                    r_d.done = 1'b1;
                    r_d.ok   = 1'b0;
                    r_d.cnt  = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            AP_GAP: begin
                r_d.st = AP_REQ;
            end
            default: r_d.st = AP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: AP_IDLE, rnd: '0, cnt: '0, done: 1'b0, ok: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign upd_req = (r_q.st == AP_REQ);
    assign done    = r_q.done;
    assign ok      = r_q.ok;

    assert_req_drops_after_ack_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        (upd_req && upd_ack) |=> !upd_req);

    assert_wait_bounded_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        upd_req |-> (r_q.cnt < CNT_W'(TO_CYC)));

    assert_timeout_withdraws_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        (done && !ok) |-> !upd_req);

endmodule

// File: rtl/rx_streak_track.sv
module rx_streak_track #(
    parameter int unsigned TAP_W = 6,
    parameter int unsigned LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             rec_valid,
    input  logic             rec_pass,
    input  logic [TAP_W-1:0] rec_tap,
    output logic [LEN_W-1:0] best_len,
    output logic [TAP_W-1:0] best_end
);
    typedef struct packed {
        logic [LEN_W-1:0] cur;
        logic [LEN_W-1:0] best;
        logic [TAP_W-1:0] last;
    } trk_t;

    trk_t r_q, r_d;
    logic [LEN_W-1:0] run_inc;

    always_comb begin
        r_d     = r_q;
        run_inc = r_q.cur + 1'b1;
        if (clr) begin
            r_d = '0;
        end else if (rec_valid) begin
            if (rec_pass) begin
                r_d.cur = run_inc;
                if (run_inc > r_q.best) begin
                    r_d.best = run_inc;
                    r_d.last = rec_tap;
                end
            end else begin
                r_d.cur = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign best_len = r_q.best;
    assign best_end = r_q.last;

    assert_best_never_shrinks_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        (rec_valid && !clr) |=> (best_len >= $past(best_len)));

    assert_fail_clears_run_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        (rec_valid && !rec_pass && !clr) |=> (r_q.cur == '0));

    assert_run_within_best_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        r_q.cur <= r_q.best);

endmodule

// File: rtl/rx_tap_sweep.sv
module rx_tap_sweep
    import rx_tune_pkg::*;
#(
    parameter int unsigned TAP_W      = 6,
    parameter int unsigned NUM_TAPS   = 40,
    parameter int unsigned TO_CYC     = 16,
    parameter int unsigned MODE_W     = 3,
    parameter int unsigned HS200_CODE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [MODE_W-1:0] timing_mode,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [TAP_W-1:0]  final_tap,
    output logic [TAP_W-1:0]  tap_value,
    output logic              upd_req,
    input  logic              upd_ack,
    output logic              test_req,
    input  logic              test_rsp_valid,
    input  logic              test_pass
);
    localparam int unsigned LEN_W    = $clog2(NUM_TAPS + 1);
    localparam logic [TAP_W-1:0] LAST_TAP = TAP_W'(NUM_TAPS - 1);

    typedef struct packed {
        sweep_st_e        st;
        logic [TAP_W-1:0] tap;
        logic             go;
        logic             done;
        logic             err;
        logic [TAP_W-1:0] fin;
    } sw_t;

    sw_t r_q, r_d;

    logic             apl_done, apl_ok;
    logic             trk_clr, rec_valid, rec_pass;
    logic [LEN_W-1:0] best_len;
    logic [TAP_W-1:0] best_end;
    logic [TAP_W-1:0] centre;

    assign centre = best_end - TAP_W'(best_len >> 1);

    always_comb begin
        r_d       = r_q;
        r_d.go    = 1'b0;
        r_d.done  = 1'b0;
        trk_clr   = 1'b0;
        rec_valid = 1'b0;
        rec_pass  = 1'b0;
        unique case (r_q.st)
            SW_IDLE: begin
                if (start && (timing_mode == MODE_W'(HS200_CODE))) begin
                    r_d.st  = SW_APPLY;
                    r_d.tap = '0;
                    r_d.go  = 1'b1;
                    r_d.err = 1'b0;
                    trk_clr = 1'b1;
                end
            end
            SW_APPLY: begin
                if (apl_done) begin
                    if (apl_ok) begin
                        r_d.st = SW_TEST;
                    end else begin
                        rec_valid = 1'b1;
                        if (r_q.tap == LAST_TAP) begin
                            r_d.st = SW_EVAL;
                        end else begin
                            r_d.tap = r_q.tap + 1'b1;
                            r_d.go  = 1'b1;
                        end
                    end
                end
            end
            SW_TEST: begin
                if (test_rsp_valid) begin
                    rec_valid = 1'b1;
                    rec_pass  = test_pass;
                    if (r_q.tap == LAST_TAP) begin
                        r_d.st = SW_EVAL;
                    end else begin
                        r_d.st  = SW_APPLY;
                        r_d.tap = r_q.tap + 1'b1;
                        r_d.go  = 1'b1;
                    end
                end
            end
            SW_EVAL: begin
                if (best_len == '0) begin
                    r_d.st   = SW_IDLE;
                    r_d.done = 1'b1;
                    r_d.err  = 1'b1;
                end else begin
                    r_d.st  = SW_FINAL;
                    r_d.tap = centre;
                    r_d.go  = 1'b1;
                end
            end
            SW_FINAL: begin
                if (apl_done) begin
                    r_d.st   = SW_IDLE;
                    r_d.done = 1'b1;
                    r_d.err  = !apl_ok;
                    if (apl_ok) begin
                        r_d.fin = r_q.tap;
                    end
                end
            end
            default: r_d.st = SW_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: SW_IDLE, tap: '0, go: 1'b0, done: 1'b0,
                     err: 1'b0, fin: '0};
        end else begin
            r_q <= r_d;
        end
    end

    rx_tap_apply #(
        .TO_CYC (TO_CYC)
    ) u_apply (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (r_q.go),
        .upd_ack (upd_ack),
        .upd_req (upd_req),
        .done    (apl_done),
        .ok      (apl_ok)
    );

    rx_streak_track #(
        .TAP_W (TAP_W),
        .LEN_W (LEN_W)
    ) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (trk_clr),
        .rec_valid (rec_valid),
        .rec_pass  (rec_pass),
        .rec_tap   (r_q.tap),
        .best_len  (best_len),
        .best_end  (best_end)
    );

    assign busy      = (r_q.st != SW_IDLE);
    assign done      = r_q.done;
    assign err       = r_q.err;
    assign final_tap = r_q.fin;
    assign tap_value = r_q.tap;
    assign test_req  = (r_q.st == SW_TEST);

    assert_test_tap_in_range_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        test_req |-> (tap_value <= LAST_TAP));

    assert_tap_stable_in_req_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        ((upd_req || test_req) && $past(upd_req || test_req)) |-> $stable(tap_value));

    assert_done_single_R10: assert property (
        @(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_idle_after_done_R10: assert property (
        @(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_no_req_when_idle_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        !busy |-> (!test_req && !upd_req));

endmodule

// File: tb/rx_tap_sweep_tb.sv
module rx_tap_sweep_tb;
    localparam int NT  = 40;
    localparam int TO  = 16;
    localparam int ACK = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] timing_mode = 3'b100;
    logic       busy, done, err, upd_req, test_req;
    logic [5:0] final_tap, tap_value;
    logic       upd_ack = 1'b0;
    logic       test_rsp_valid = 1'b0;
    logic       test_pass = 1'b0;

    always #5 clk = ~clk;

    rx_tap_sweep u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .timing_mode(timing_mode),
        .busy(busy), .done(done), .err(err), .final_tap(final_tap),
        .tap_value(tap_value), .upd_req(upd_req), .upd_ack(upd_ack),
        .test_req(test_req), .test_rsp_valid(test_rsp_valid), .test_pass(test_pass)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [63:0] pass_mask = '0;
    logic [63:0] stall_mask = '0;
    logic        stall_final = 1'b0;
    logic [63:0] tested = '0;
    int  upd_rises = 0;
    int  tests_seen = 0;
    int  acnt = 0, tcnt = 0;
    logic prev_req = 1'b0, prev_test = 1'b0;
    logic order_bad = 1'b0;
    int  last_tested = -1;
    logic [5:0] last_req_tap = '0;
    logic done_seen = 1'b0;

    task automatic chk(input string req, input logic ok, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // responders and monitor, all at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            upd_ack = 1'b0;
            test_rsp_valid = 1'b0;
            if (upd_req && !prev_req) begin
                upd_rises++;
                last_req_tap = tap_value;
            end
            if (test_req && !prev_test) begin
                tests_seen++;
                if (int'(tap_value) <= last_tested || tap_value >= NT) order_bad = 1'b1;
                last_tested = int'(tap_value);
                tested[tap_value] = 1'b1;
            end
            if (done) done_seen = 1'b1;
            prev_req = upd_req;
            prev_test = test_req;
            if (upd_req) begin
                if (stall_mask[tap_value] || (stall_final && tests_seen == NT)) begin
                    acnt = 0;
                end else if (acnt == ACK - 1) begin
                    upd_ack = 1'b1;
                    acnt = 0;
                end else begin
                    acnt++;
                end
            end else acnt = 0;
            if (test_req) begin
                if (tcnt == 1) begin
                    test_rsp_valid = 1'b1;
                    test_pass = pass_mask[tap_value];
                    tcnt = 0;
                end else tcnt++;
            end else tcnt = 0;
        end
    end

    function automatic void model(input logic [63:0] eff, output int blen, output int bend);
        int cur;
        cur = 0; blen = 0; bend = 0;
        for (int i = 0; i < NT; i++) begin
            if (eff[i]) begin
                cur++;
                if (cur > blen) begin blen = cur; bend = i; end
            end else cur = 0;
        end
    endfunction

    task automatic run(input logic [63:0] pm, input logic [63:0] sm, input logic sf,
                       input string tag);
        logic [63:0] eff;
        int blen, bend, exp_fin, exp_rises, ns, wait_cyc;
        logic exp_err;
        pass_mask = pm; stall_mask = sm; stall_final = sf;
        tested = '0; upd_rises = 0; tests_seen = 0; order_bad = 1'b0;
        last_tested = -1; done_seen = 1'b0;
        eff = pm & ~sm;
        model(eff, blen, bend);
        ns = $countones(sm[NT-1:0]);
        exp_fin = bend - blen / 2;
        exp_err = (blen == 0) || sf;
        exp_rises = 2 * (NT - ns) + ns + ((blen == 0) ? 0 : (sf ? 1 : 2));
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_cyc = 0;
        while (!done && wait_cyc < 20000) begin
            @(negedge clk);
            wait_cyc++;
        end
        if (!done) begin
            chk({"R10 watchdog ", tag}, 1'b0, 0, 1);
            return;
        end
        chk({"R8 R9 err ", tag}, err == exp_err, int'(err), int'(exp_err));
        if (!exp_err) begin
            chk({"R6 R7 final_tap ", tag}, final_tap == 6'(exp_fin), int'(final_tap), exp_fin);
            chk({"R7 last load tap ", tag}, last_req_tap == 6'(exp_fin), int'(last_req_tap), exp_fin);
        end
        chk({"R4 R5 R8 update count ", tag}, upd_rises == exp_rises, upd_rises, exp_rises);
        chk({"R3 R5 tested set ", tag}, tested[NT-1:0] == ~sm[NT-1:0],
            $countones(tested[NT-1:0]), NT - ns);
        chk({"R3 order ", tag}, !order_bad, int'(order_bad), 0);
        @(negedge clk);
        chk({"R10 done width ", tag}, !done && !busy, int'(done) + int'(busy), 0);
    endtask

    initial begin
        logic [63:0] m;
        #1;
        chk("R1 reset outputs", !busy && !done && !err && !upd_req && !test_req && tap_value == 0,
            int'(busy) + int'(done) + int'(err) + int'(upd_req) + int'(test_req), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", !busy && !upd_req && tap_value == 0, int'(busy), 0);

        // R2: wrong timing code ignored
        timing_mode = 3'b010;
        upd_rises = 0; done_seen = 1'b0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (30) @(negedge clk);
        chk("R2 start ignored busy", !busy && !done_seen, int'(busy), 0);
        chk("R2 start ignored updates", upd_rises == 0, upd_rises, 0);
        timing_mode = 3'b100;

        run({64{1'b1}}, '0, 1'b0, "all pass");
        run('0, '0, 1'b0, "none pass R8");
        run(64'h1, '0, 1'b0, "tap0 only");
        run(64'h1 << 39, '0, 1'b0, "tap39 only");
        run(64'h1 << 40 | 64'h1 << 41, '0, 1'b0, "beyond range R8");
        m = '0; for (int i = 10; i <= 20; i++) m[i] = 1'b1;
        run(m, '0, 1'b0, "window 10-20");
        m = '0; for (int i = 3; i <= 6; i++) m[i] = 1'b1;
        for (int i = 20; i <= 23; i++) m[i] = 1'b1;
        run(m, '0, 1'b0, "tie keeps earliest R6");
        m = '0; for (int i = 2; i <= 4; i++) m[i] = 1'b1;
        for (int i = 30; i <= 36; i++) m[i] = 1'b1;
        run(m, '0, 1'b0, "later longer R6");
        m = '0; for (int i = 5; i <= 25; i++) m[i] = 1'b1;
        run(m, 64'h1 << 15, 1'b0, "stall splits R5");
        run({64{1'b1}}, (64'h1 << 0) | (64'h1 << 39), 1'b0, "stall ends R5");
        run({64{1'b1}}, '0, 1'b1, "final timeout R9");
        for (int a = 0; a < NT; a += 4) begin
            for (int k = 0; k < 4; k++) begin
                int len;
                len = (k == 0) ? 1 : (k == 1) ? 2 : (k == 2) ? 5 : 13;
                m = '0;
                for (int i = a; i < a + len && i < NT; i++) m[i] = 1'b1;
                run(m, '0, 1'b0, "sweep window R6 R7");
            end
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(150000 * 10);
        n_chk++; n_bad++;
        $display("FAIL R10 global watchdog actual=0 expected=1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule